// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block turns each CPU access into a physical memory selection. The CPU sees a 64K address space in four 16K sections, A to D. These sections map onto a larger RAM made of 16K pages and onto a ROM made of two halves. The CPU programs the block through two byte-wide page registers on I/O ports.

The low register places a base page in section A. The page after it follows automatically into section B. The high register does the same for sections C and D. Control bits in the low register can do three things:

- bring RAM into section A in place of the first ROM half;
- lay the second ROM half over section D;
- protect RAM in section A against writes.

An optional split-mode input gives section D its own page register, so that C and D can be paged separately.

For every access the block reports a physical page number, a ROM select, the ROM half and a write-enable gate. The memory arrays themselves sit outside the block.

Top module: `mem_page_ctrl`

## Requirements
- R1: After reset, all page registers read back 0. Section A shows ROM half 0, B shows page 1, C shows page 0 and D shows page 1.
- R2: A page register loads the full byte of `ioWrData` on the clock edge where `ioWrite` is high and `ioPort` selects it. The low register is at port 250, the high register at 251 and the split register at 252. Other ports leave every register unchanged.
- R3: `ioRdData` returns the full byte stored in the register addressed by `ioPort`. An unused port reads 0.
- R4: With low-register bit 5 set, section A maps RAM page P. Here P is low-register bits 4:0.
- R5: Section B always maps RAM page (P+1) mod 32, so P=31 gives page 0.
- R6: Section C maps page Q, where Q is high-register bits 4:0. With split mode off, section D maps page (Q+1) mod 32. Any Q may be used.
- R7: With low-register bit 5 clear, section A selects ROM with `romHalf`=0.
- R8: With low-register bit 6 set, section D selects ROM with `romHalf`=1, whatever the split mode.
- R9: With low-register bit 7 set, a write to section A gives no write enable.
- R10: A write to a section that shows ROM never gives a write enable. While `romSel` is 1, `physPage` reads 0.
- R11: With `splitMode` high and bit 6 clear, section D maps the split register's bits 4:0, not Q+1.
- R12: `writeEn` is high only when `cpuWrite` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioWrite | input | 1 | I/O write strobe |
| ioPort | input | 8 | Low byte of the I/O address |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | Read-back of the addressed register |
| splitMode | input | 1 | Page section D from its own register |
| cpuAddrTop | input | 2 | CPU address bits 15:14 (section) |
| cpuWrite | input | 1 | Current access is a write |
| physPage | output | 5 | Physical RAM page |
| romSel | output | 1 | Access goes to ROM |
| romHalf | output | 1 | Selected ROM half |
| writeEn | output | 1 | Write gate to RAM |

## Verification
The low register is swept through all 256 byte values while the high register is held fixed. Every section is probed as a write on each value. This separates the base/next-page roll, the modulo-32 wrap, the two ROM overlays and the write protect, in every combination of the three control bits.

A second sweep runs all 256 high-register values, which shows that any page can be the base of the upper pair. A split-mode sweep of the extra register shows D decoupling from C, and also shows the ROM overlay still winning over it.

Writes to neighbouring ports, and reads with the write flag low, show that mismatched strobes and read accesses change nothing.

// File: rtl/mem_page_pkg.sv
package mem_page_pkg;
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic wrUpper;
  } regStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_LOW,
    RD_HIGH,
    RD_UPPER
  } rdSel_t;
endpackage

// File: rtl/mem_page_decode.sv
module mem_page_decode
  import mem_page_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_LOW = 8'd250,
  parameter logic [PORT_W-1:0] PORT_HIGH = 8'd251,
  parameter logic [PORT_W-1:0] PORT_UPPER = 8'd252
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrite,
  input  logic [PORT_W-1:0] ioPort,
  output regStrobes_t       strobes,
  output rdSel_t            rdSel
);
  always_comb begin
    strobes = '0;
    rdSel = RD_NONE;
    if (ioPort == PORT_LOW) begin
      rdSel = RD_LOW;
      strobes.wrLow = ioWrite;
    end else if (ioPort == PORT_HIGH) begin
      rdSel = RD_HIGH;
      strobes.wrHigh = ioWrite;
    end else if (ioPort == PORT_UPPER) begin
      rdSel = RD_UPPER;
      strobes.wrUpper = ioWrite;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrLow, strobes.wrHigh, strobes.wrUpper})); // R2
endmodule

// File: rtl/mem_page_datapath.sv
module mem_page_datapath
  import mem_page_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic              splitMode,
  input  logic [1:0]        cpuSec,
  input  logic              cpuWrite,
  output logic [PAGE_W-1:0] physPage,
  output logic              romSel,
  output logic              romHalf,
  output logic              writeEn
);
  localparam int RAM_A_BIT = 5;
  localparam int ROM_D_BIT = 6;
  localparam int WP_A_BIT = 7;
  localparam logic [PAGE_W-1:0] ONE_PAGE = PAGE_W'(1);

  logic [DATA_W-1:0] lowReg, highReg, upperReg;
  logic [PAGE_W-1:0] lowPage, highPage, upperPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowReg <= '0;
      highReg <= '0;
      upperReg <= '0;
    end else begin
      if (strobes.wrLow) lowReg <= ioWrData;
      if (strobes.wrHigh) highReg <= ioWrData;
      if (strobes.wrUpper) upperReg <= ioWrData;
    end
  end

  assign lowPage = lowReg[PAGE_W-1:0];
  assign highPage = highReg[PAGE_W-1:0];
  assign upperPage = upperReg[PAGE_W-1:0];

  always_comb begin
    case (rdSel)
      RD_LOW:   ioRdData = lowReg;
      RD_HIGH:  ioRdData = highReg;
      RD_UPPER: ioRdData = upperReg;
      default:  ioRdData = '0;
    endcase
  end

  always_comb begin
    physPage = '0;
    romSel = 1'b0;
    romHalf = 1'b0;
    case (cpuSec)
      2'd0: begin
        if (lowReg[RAM_A_BIT]) physPage = lowPage;
        else romSel = 1'b1;
      end
      2'd1: physPage = lowPage + ONE_PAGE;
      2'd2: physPage = highPage;
      default: begin
        if (lowReg[ROM_D_BIT]) begin
          romSel = 1'b1;
          romHalf = 1'b1;
        end else if (splitMode) begin
          physPage = upperPage;
        end else begin
          physPage = highPage + ONE_PAGE;
        end
      end
    endcase
  end

  assign writeEn = cpuWrite & ~romSel & ~((cpuSec == 2'd0) & lowReg[WP_A_BIT]);

  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLow |=> lowReg == $past(ioWrData)); // R2
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrHigh |=> $stable(highReg)); // R2
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> !writeEn); // R10
  AST_WP_SECTION_A: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSec == 2'd0 && lowReg[WP_A_BIT]) |-> !writeEn); // R9
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrite |-> !writeEn); // R12
endmodule

// File: rtl/mem_page_ctrl.sv
module mem_page_ctrl
  import mem_page_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrite,
  input  logic [PORT_W-1:0] ioPort,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic              splitMode,
  input  logic [1:0]        cpuAddrTop,
  input  logic              cpuWrite,
  output logic [PAGE_W-1:0] physPage,
  output logic              romSel,
  output logic              romHalf,
  output logic              writeEn
);
  regStrobes_t strobes;
  rdSel_t rdSel;

  mem_page_decode #(.PORT_W(PORT_W)) i_decode (
    .clk(clk), .rstN(rstN), .ioWrite(ioWrite), .ioPort(ioPort),
    .strobes(strobes), .rdSel(rdSel)
  );

  mem_page_datapath #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .splitMode(splitMode),
    .cpuSec(cpuAddrTop), .cpuWrite(cpuWrite), .physPage(physPage),
    .romSel(romSel), .romHalf(romHalf), .writeEn(writeEn)
  );
endmodule

// File: tb/test_mem_page_ctrl.sv
module test_mem_page_ctrl;
  logic clk = 0, rstN = 0, ioWrite = 0, splitMode = 0, cpuWrite = 0;
  logic [7:0] ioPort = 0, ioWrData = 0, ioRdData;
  logic [1:0] cpuAddrTop = 0;
  logic [4:0] physPage;
  logic romSel, romHalf, writeEn;
  int errors = 0, checks = 0, cycles = 0;

  mem_page_ctrl i_mem_page_ctrl (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic ioWr(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    ioPort = port; ioWrData = data; ioWrite = 1;
    @(negedge clk);
    ioWrite = 0;
  endtask

  task automatic chkRead(input logic [7:0] port, input logic [7:0] exp, input string req);
    ioPort = port; #1;
    checks++;
    if (ioRdData !== exp) begin
      errors++;
      $display("FAIL %s read port %0d: actual=%0h expected=%0h", req, port, ioRdData, exp);
    end
  endtask

  // Expected {page, romSel, romHalf, writeEn} from the requirements
  function automatic logic [7:0] expMap(input int sec, input logic [7:0] lo, input logic [7:0] hi,
                                        input logic [7:0] up, input logic split, input logic wr);
    logic [4:0] pg = 0; logic rs = 0, rh = 0, we;
    if (sec == 0) begin if (lo[5]) pg = lo[4:0]; else rs = 1; end         // R4 R7
    else if (sec == 1) pg = 5'((lo[4:0] + 1) % 32);                        // R5
    else if (sec == 2) pg = hi[4:0];                                       // R6
    else if (lo[6]) begin rs = 1; rh = 1; end                              // R8
    else if (split) pg = up[4:0];                                          // R11
    else pg = 5'((hi[4:0] + 1) % 32);                                      // R6
    we = wr && !rs && !(sec == 0 && lo[7]);                                // R9 R10 R12
    return {pg, rs, rh, we};
  endfunction

  task automatic chkMap(input int sec, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] up, input logic wr, input string req);
    logic [7:0] e, a;
    cpuAddrTop = 2'(sec); cpuWrite = wr; #1;
    e = expMap(sec, lo, hi, up, splitMode, wr);
    a = {(romSel ? 5'd0 : physPage), romSel, romHalf, writeEn};
    if (romSel && physPage != 0) a = 8'hFF; // R10 page reads 0 under ROM
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s sec=%0d lo=%0h hi=%0h: actual=%0h expected=%0h", req, sec, lo, hi, a, e);
    end
  endtask

  initial begin
    #23 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chkRead(250, 0, "R1"); chkRead(251, 0, "R1"); chkRead(252, 0, "R1");
    for (int s = 0; s < 4; s++) chkMap(s, 0, 0, 0, 1, "R1");

    // Low register sweep: R2 R3 R4 R5 R7 R8 R9 R10
    ioWr(251, 8'd9);
    for (int v = 0; v < 256; v++) begin
      ioWr(250, 8'(v));
      chkRead(250, 8'(v), "R2_R3");
      for (int s = 0; s < 4; s++) chkMap(s, 8'(v), 8'd9, 0, 1, "R4_R5_R7_R8_R9_R10");
      chkMap(0, 8'(v), 8'd9, 0, 0, "R12");
    end

    // High register sweep: R6 rolling pair with wrap
    ioWr(250, 8'h20);
    for (int v = 0; v < 256; v++) begin
      ioWr(251, 8'(v));
      chkRead(251, 8'(v), "R2_R3");
      chkMap(2, 8'h20, 8'(v), 0, 1, "R6");
      chkMap(3, 8'h20, 8'(v), 0, 1, "R6");
    end

    // Split mode: R11, and ROM overlay still wins (R8)
    ioWr(251, 8'd4);
    splitMode = 1;
    for (int v = 0; v < 64; v++) begin
      ioWr(252, 8'(v * 4 + 1));
      chkRead(252, 8'(v * 4 + 1), "R3");
      chkMap(3, 8'h20, 8'd4, 8'(v * 4 + 1), 1, "R11");
      chkMap(2, 8'h20, 8'd4, 8'(v * 4 + 1), 1, "R11");
    end
    ioWr(250, 8'h60);
    chkMap(3, 8'h60, 8'd4, 8'd253, 1, "R8");
    splitMode = 0;

    // Mismatched ports: R2 no effect, R3 unused reads 0
    ioWr(250, 8'h2B); ioWr(251, 8'h17); ioWr(252, 8'h05);
    ioWr(249, 8'hFF); ioWr(253, 8'hFF); ioWr(8'd0, 8'hFF); ioWr(8'd122, 8'hFF);
    chkRead(250, 8'h2B, "R2"); chkRead(251, 8'h17, "R2"); chkRead(252, 8'h05, "R2");
    chkRead(253, 8'h00, "R3"); chkRead(249, 8'h00, "R3");
    for (int s = 0; s < 4; s++) chkMap(s, 8'h2B, 8'h17, 8'h05, 1, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule